// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block decides which of eight interrupt sources a small 8-bit processor core services next. Each source has a request flag, an enable bit and a two-bit priority level (0 lowest, 3 highest). A single global enable gates every source. From the pending, enabled requests that may preempt the level now in service, the block picks one. It then registers a one-cycle take strobe together with that source's fixed vector address, source index and level.

The controller keeps one in-service bit for each priority level. A take strobe sets the bit for the level it took. A return-from-interrupt pulse clears the highest bit that is set. Request flags are stored in the block and can be set by hardware event pulses or written by software. Only the timer 0 and timer 1 flags, and the external 0 and external 1 flags in edge mode, are cleared by hardware when their vector is taken. Two sources are composites of two flags: serial (receive OR transmit) and timer 2 (overflow OR capture). These flags stay set until software clears them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: During and after reset all flags read 0, no in-service bit is set, and `take_o` is low.
- R2: When an eligible request is pending after a clock edge, `take_o` is high for one cycle after the next edge. `vector_o` is then 0003h + 8 × source index, with indices ext0=0, timer0=1, ext1=2, timer1=3, serial=4, timer2=5, ext2=6, ext3=7. `src_o` gives that index and `level_o` gives its priority.
- R3: The priority of source i is `src_prio[2i+1:2i]`. A pending request at a higher level is taken before any request at a lower level, whatever its index.
- R4: Among pending requests at the same level, the lowest source index is taken.
- R5: While `glb_en` is low, no vector is taken. Pending flags are kept.
- R6: A source whose `src_en` bit is low is never taken. Its flag is kept.
- R7: A request is taken only if no in-service bit is set, or its level is strictly above the highest in-service level.
- R8: A `reti_i` pulse clears the highest set in-service bit, and no new vector is issued at the edge where it is seen.
- R9: The timer 0 and timer 1 flags clear at the edge that takes their vector. A hardware set of the same flag at that edge wins.
- R10: The ext0 and ext1 flags clear on their take only when their `ext_edge` bit is 1. With the bit at 0 the flag stays set.
- R11: Hardware never clears the serial, timer 2, ext2 or ext3 flags. A still-set flag of this kind is taken again once its level leaves service.
- R12: Raw flag bits are ext0=0, timer0=1, ext1=2, timer1=3, serial rx=4, serial tx=5, timer2 overflow=6, timer2 capture=7, ext2=8, ext3=9. A `flag_wr` bit loads `flag_wdata` into that flag. This write overrides a hardware set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 8 | Per-source enable, bit i = source i |
| src_prio | input | 16 | Two-bit level per source |
| ext_edge | input | 2 | Edge mode for ext0 (bit 0) and ext1 (bit 1) |
| flag_set | input | 10 | Hardware event pulses per raw flag |
| flag_wr | input | 10 | Software write strobes per raw flag |
| flag_wdata | input | 10 | Software write data per raw flag |
| reti_i | input | 1 | Return-from-interrupt pulse |
| flags_o | output | 10 | Current raw flags |
| take_o | output | 1 | One-cycle vector strobe |
| vector_o | output | 16 | Vector address of the taken source |
| src_o | output | 3 | Index of the taken source |
| level_o | output | 2 | Level of the taken source |
| in_service_o | output | 4 | In-service bit per level |

## Verification
The bench sets a high-priority source against a lower-index, low-priority one. A design that arbitrated by index alone would vector ext0 instead of ext3. It issues a return pulse while another request waits, so a design that ignored the one-cycle suppression would strobe on the return edge. It raises an equal-level request under a running handler, where a non-strict compare would preempt. It fires a timer set at the very edge its vector is taken, which a design that clears with priority would lose. It also checks that level-mode external, serial, timer 2 and ext3 flags survive the take and are re-vectored once the return pulse drops their level.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC     = 8;
  localparam int PRIO_W   = 2;
  localparam int NLVL     = 1 << PRIO_W;
  localparam int IDX_W    = $clog2(NSRC);
  localparam int NRAW     = 10;
  localparam int VEC_W    = 16;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  // raw flag positions
  localparam int RF_EXT0 = 0;
  localparam int RF_TMR0 = 1;
  localparam int RF_EXT1 = 2;
  localparam int RF_TMR1 = 3;
  localparam int RF_SRX  = 4;
  localparam int RF_STX  = 5;
  localparam int RF_T2OV = 6;
  localparam int RF_T2CP = 7;
  localparam int RF_EXT2 = 8;
  localparam int RF_EXT3 = 9;

  // source indices (also fixed same-level order, lowest first)
  localparam int SI_EXT0 = 0;
  localparam int SI_TMR0 = 1;
  localparam int SI_EXT1 = 2;
  localparam int SI_TMR1 = 3;
  localparam int SI_SER  = 4;
  localparam int SI_TMR2 = 5;
  localparam int SI_EXT2 = 6;
  localparam int SI_EXT3 = 7;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction
endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/irqv_flags.sv
module irqv_flags #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] fl_q;
  logic [N-1:0] fl_d;

  // software write > hardware set > take auto-clear > hold
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (wr_i[i])       fl_d[i] = wdata_i[i];
      else if (set_i[i]) fl_d[i] = 1'b1;
      else if (clr_i[i]) fl_d[i] = 1'b0;
      else               fl_d[i] = fl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags_o = fl_q;
endmodule

// File: rtl/irqv_select.sv
module irqv_select #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 2,
  localparam int NLVL  = 1 << PRIO_W,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [NLVL-1:0]        isr_i,
  output logic                   valid_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [PRIO_W-1:0]      lvl_o
);
  logic              cur_any;
  logic [PRIO_W-1:0] cur_lvl;
  logic [NSRC-1:0]   elig;
  logic [NSRC-1:0]   lvl_hit [NLVL];

  always_comb begin
    cur_any = |isr_i;
    cur_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_i[l]) cur_lvl = PRIO_W'(l);
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    logic [PRIO_W-1:0] p;
    assign p       = prio_i[s*PRIO_W +: PRIO_W];
    assign elig[s] = req_i[s] && (!cur_any || (p > cur_lvl));
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign lvl_hit[l][s] = elig[s] && (prio_i[s*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
  end

  // higher level overrides; within a level the lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (|lvl_hit[l]) begin
        valid_o = 1'b1;
        lvl_o   = PRIO_W'(l);
        for (int s = NSRC - 1; s >= 0; s--) begin
          if (lvl_hit[l][s]) idx_o = IDX_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/irqv_nest.sv
module irqv_nest #(
  parameter int NLVL  = 4,
  localparam int LVL_W = $clog2(NLVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [NLVL-1:0]  isr_o
);
  logic [NLVL-1:0]  isr_q;
  logic [NLVL-1:0]  isr_d;
  logic [LVL_W-1:0] top;

  always_comb begin
    top = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) top = LVL_W'(l);
    end
  end

  always_comb begin
    isr_d = isr_q;
    if (push_i)                isr_d[push_lvl_i] = 1'b1;
    else if (pop_i && |isr_q)  isr_d[top]        = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   glb_en,
  input  logic [NSRC-1:0]        src_en,
  input  logic [NSRC*PRIO_W-1:0] src_prio,
  input  logic [1:0]             ext_edge,
  input  logic [NRAW-1:0]        flag_set,
  input  logic [NRAW-1:0]        flag_wr,
  input  logic [NRAW-1:0]        flag_wdata,
  input  logic                   reti_i,
  output logic [NRAW-1:0]        flags_o,
  output logic                   take_o,
  output logic [VEC_W-1:0]       vector_o,
  output logic [IDX_W-1:0]       src_o,
  output logic [PRIO_W-1:0]      level_o,
  output logic [NLVL-1:0]        in_service_o
);
  logic              srst_n;
  logic [NRAW-1:0]   raw;
  logic [NRAW-1:0]   auto_clr;
  logic [NSRC-1:0]   req;
  logic [NSRC-1:0]   gated;
  logic [NLVL-1:0]   isr;
  logic              sel_valid;
  logic [IDX_W-1:0]  sel_idx;
  logic [PRIO_W-1:0] sel_lvl;
  logic              take_now;

  logic              take_q, take_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PRIO_W-1:0] lvl_q, lvl_d;
  logic [VEC_W-1:0]  vec_q, vec_d;

  irqv_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irqv_flags #(.N(NRAW)) u_flags (
    .clk     (clk),
    .rst_n   (srst_n),
    .set_i   (flag_set),
    .clr_i   (auto_clr),
    .wr_i    (flag_wr),
    .wdata_i (flag_wdata),
    .flags_o (raw)
  );

  // source requests, composites merged
  always_comb begin
    req          = '0;
    req[SI_EXT0] = raw[RF_EXT0];
    req[SI_TMR0] = raw[RF_TMR0];
    req[SI_EXT1] = raw[RF_EXT1];
    req[SI_TMR1] = raw[RF_TMR1];
    req[SI_SER]  = raw[RF_SRX]  | raw[RF_STX];
    req[SI_TMR2] = raw[RF_T2OV] | raw[RF_T2CP];
    req[SI_EXT2] = raw[RF_EXT2];
    req[SI_EXT3] = raw[RF_EXT3];
    gated        = req & src_en & {NSRC{glb_en}};
  end

  irqv_select #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_sel (
    .req_i   (gated),
    .prio_i  (src_prio),
    .isr_i   (isr),
    .valid_o (sel_valid),
    .idx_o   (sel_idx),
    .lvl_o   (sel_lvl)
  );

  assign take_now = sel_valid && !reti_i;

  // hardware clear on vectoring, for the sources that have it
  always_comb begin
    auto_clr = '0;
    if (take_now) begin
      case (int'(sel_idx))
        SI_EXT0: auto_clr[RF_EXT0] = ext_edge[0];
        SI_TMR0: auto_clr[RF_TMR0] = 1'b1;
        SI_EXT1: auto_clr[RF_EXT1] = ext_edge[1];
        SI_TMR1: auto_clr[RF_TMR1] = 1'b1;
        default: auto_clr          = '0;
      endcase
    end
  end

  irqv_nest #(.NLVL(NLVL)) u_nest (
    .clk        (clk),
    .rst_n      (srst_n),
    .push_i     (take_now),
    .push_lvl_i (sel_lvl),
    .pop_i      (reti_i),
    .isr_o      (isr)
  );

  // registered decision, payload loads only on a take
  always_comb begin
    take_d = take_now;
    idx_d  = idx_q;
    lvl_d  = lvl_q;
    vec_d  = vec_q;
    if (take_now) begin
      idx_d = sel_idx;
      lvl_d = sel_lvl;
      vec_d = vec_of(sel_idx);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      take_q <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= '0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      idx_q  <= idx_d;
      lvl_q  <= lvl_d;
      vec_q  <= vec_d;
    end
  end

  assign flags_o      = raw;
  assign take_o       = take_q;
  assign vector_o     = vec_q;
  assign src_o        = idx_q;
  assign level_o      = lvl_q;
  assign in_service_o = isr;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
  import irqv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic [NRAW-1:0]   flag_set,
  input logic [NRAW-1:0]   flag_wr,
  input logic              reti_i,
  input logic [NRAW-1:0]   flags_o,
  input logic              take_o,
  input logic [IDX_W-1:0]  src_o,
  input logic [PRIO_W-1:0] level_o,
  input logic [NLVL-1:0]   in_service_o
);
  // R2: a taken level is marked in service at the same edge
  a_r2_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> in_service_o[level_o]);

  // R7: nothing at or above the taken level was in service before
  a_r7_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(in_service_o) >> level_o) == '0));

  // R5: no take when global enable was low
  a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glb_en) |-> !take_o);

  // R8: return pulse drops exactly one level and blocks a take
  a_r8_reti_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && (in_service_o != '0)) |=>
      (!take_o && ($countones(in_service_o) == $countones($past(in_service_o)) - 1)));

  // R9: timer 0 flag cleared by its take unless re-set or written
  a_r9_tmr0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == IDX_W'(SI_TMR0) && !$past(flag_set[RF_TMR0]) && !$past(flag_wr[RF_TMR0]))
      |-> !flags_o[RF_TMR0]);

  // R11: serial flags are kept through a take
  a_r11_serial_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == IDX_W'(SI_SER) && ($past(flag_wr[RF_STX:RF_SRX]) == 2'b00))
      |-> ((flags_o[RF_STX:RF_SRX] & $past(flags_o[RF_STX:RF_SRX])) == $past(flags_o[RF_STX:RF_SRX])));
endmodule

bind irq_vector_ctrl irqv_chk u_chk (
  .clk          (clk),
  .rst_n        (srst_n),
  .glb_en       (glb_en),
  .flag_set     (flag_set),
  .flag_wr      (flag_wr),
  .reti_i       (reti_i),
  .flags_o      (flags_o),
  .take_o       (take_o),
  .src_o        (src_o),
  .level_o      (level_o),
  .in_service_o (in_service_o)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en;
  logic [7:0]  src_en;
  logic [15:0] src_prio;
  logic [1:0]  ext_edge;
  logic [9:0]  flag_set, flag_wr, flag_wdata;
  logic        reti_i;
  logic [9:0]  flags_o;
  logic        take_o;
  logic [15:0] vector_o;
  logic [2:0]  src_o;
  logic [1:0]  level_o;
  logic [3:0]  in_service_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en),
    .src_prio(src_prio), .ext_edge(ext_edge), .flag_set(flag_set),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .reti_i(reti_i),
    .flags_o(flags_o), .take_o(take_o), .vector_o(vector_o),
    .src_o(src_o), .level_o(level_o), .in_service_o(in_service_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; glb_en = 1'b1; src_en = 8'hFF; src_prio = 16'h0;
    ext_edge = 2'b11; flag_set = '0; flag_wr = '0; flag_wdata = '0; reti_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic pulse_set(input logic [9:0] m);
    flag_set = m; tick(); flag_set = '0;
  endtask

  task automatic reti();
    reti_i = 1'b1; tick(); reti_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "flags", flags_o, 0);
    chk("R1", "isr", in_service_o, 0);
    chk("R1", "take", take_o, 0);
  endtask

  task automatic t_basic();
    do_reset();
    pulse_set(10'b0000000010); tick();
    chk("R2", "take", take_o, 1);
    chk("R2", "vector", vector_o, 16'h000B);
    chk("R2", "src", src_o, 1);
    chk("R9", "tmr0 flag", flags_o[1], 0);
    tick();
    chk("R2", "one-cycle strobe", take_o, 0);
    reti();
    chk("R8", "isr after reti", in_service_o, 0);
  endtask

  task automatic t_order();
    do_reset();
    pulse_set(10'b1000010100); tick();
    chk("R4", "src", src_o, 2);
    chk("R4", "vector", vector_o, 16'h0013);
    chk("R10", "ext1 edge flag", flags_o[2], 0);
    reti();
    chk("R8", "no take on reti edge", take_o, 0);
    chk("R8", "isr", in_service_o, 0);
    tick();
    chk("R11", "serial take", take_o, 1);
    chk("R11", "serial vector", vector_o, 16'h0023);
    chk("R11", "rx kept", flags_o[4], 1);
  endtask

  task automatic t_prio();
    do_reset();
    src_prio = 16'hC000;
    pulse_set(10'b1000000001); tick();
    chk("R3", "vector", vector_o, 16'h003B);
    chk("R3", "level", level_o, 3);
    repeat (3) tick();
    chk("R7", "no take under level 3", take_o, 0);
    reti(); tick();
    chk("R11", "ext3 retaken", src_o, 7);
    chk("R11", "ext3 take", take_o, 1);
  endtask

  task automatic t_preempt();
    do_reset();
    src_prio = 16'h0841;
    pulse_set(10'b0000000001); tick();
    chk("R7", "ext0 level", level_o, 1);
    chk("R7", "isr", in_service_o, 4'b0010);
    pulse_set(10'b0000001000); tick();
    chk("R7", "equal level blocked", take_o, 0);
    pulse_set(10'b0010000000); tick();
    chk("R7", "tmr2 preempts", vector_o, 16'h002B);
    chk("R7", "nested isr", in_service_o, 4'b0110);
    reti();
    chk("R8", "highest popped", in_service_o, 4'b0010);
    tick();
    chk("R11", "tmr2 retaken", take_o, 1);
    chk("R11", "tmr2 src", src_o, 5);
    flag_wr = 10'b0010000000; flag_wdata = '0; tick(); flag_wr = '0;
    reti(); tick();
    chk("R7", "tmr1 still blocked", take_o, 0);
    reti(); tick();
    chk("R7", "tmr1 after return", vector_o, 16'h001B);
    chk("R7", "tmr1 take", take_o, 1);
  endtask

  task automatic t_enables();
    do_reset();
    glb_en = 1'b0;
    pulse_set(10'b0000000001); tick(); tick();
    chk("R5", "global off", take_o, 0);
    chk("R5", "flag kept", flags_o[0], 1);
    glb_en = 1'b1; tick();
    chk("R5", "taken after enable", take_o, 1);
    do_reset();
    src_en = 8'hFE;
    pulse_set(10'b0000000001); tick(); tick();
    chk("R6", "source off", take_o, 0);
    chk("R6", "flag kept", flags_o[0], 1);
    src_en = 8'hFF; tick();
    chk("R6", "taken after enable", take_o, 1);
  endtask

  task automatic t_level();
    do_reset();
    ext_edge = 2'b00;
    pulse_set(10'b0000000001); tick();
    chk("R10", "level take", take_o, 1);
    chk("R10", "level flag kept", flags_o[0], 1);
  endtask

  task automatic t_sw();
    do_reset();
    flag_wr = 10'b0000001000; flag_wdata = 10'b0000001000; tick(); flag_wr = '0;
    chk("R12", "sw set", flags_o[3], 1);
    tick();
    chk("R12", "sw take", vector_o, 16'h001B);
    chk("R9", "tmr1 cleared", flags_o[3], 0);
    reti();
    flag_wr = 10'b0100000000; flag_wdata = '0; flag_set = 10'b0100000000;
    tick(); flag_wr = '0; flag_set = '0;
    chk("R12", "write beats set", flags_o[8], 0);
    tick();
    chk("R12", "no take", take_o, 0);
  endtask

  task automatic t_setwins();
    do_reset();
    pulse_set(10'b0000000010);
    flag_set = 10'b0000000010; tick(); flag_set = '0;
    chk("R9", "take", take_o, 1);
    chk("R9", "set beats clear", flags_o[1], 1);
    reti(); tick();
    chk("R9", "retaken", src_o, 1);
    chk("R9", "now cleared", flags_o[1], 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_prio();
    t_preempt();
    t_enables();
    t_level();
    t_sw();
    t_setwins();
    summary();
    $finish;
  end
endmodule